// File: doc/BRIEF.md
# Cross-Bank Gap Checker for Auto-Precharge Commands

This block watches the command stream of a DDR2-style memory controller and remembers the latest read or write that carried auto-precharge. For every new command aimed at a bank other than the remembered one, it decides in the same cycle whether enough clock cycles have passed since that auto-precharge command. The required gap depends on two things: whether the remembered command was a read or a write, and whether the new command is a read, a write, or a bank activate or precharge. A scheduler presents its candidate command, reads `cmd_ok`, and holds the command back while `cmd_ok` is low.

Configuration comes from three inputs: CAS latency in cycles, the burst length as a choice between 4 and 8 beats, and the write-to-read recovery time in picoseconds. The recovery time is rounded up to whole clock periods inside the block. A refused command is not taken as issued and does not change the tracked state. `cmd_viol` marks any presented command that breaks the spacing. Commands to the tracked bank itself, and commands outside the checked set, are let through.

Top module: `ap_gap_checker`

## Requirements
- R1: After reset nothing is tracked: every presented command gives `cmd_ok`=1 and `cmd_viol`=0, including precharge-all.
- R2: After an accepted write with auto-precharge (op 3, ap=1), a read (op 2, with or without ap) to another bank is allowed only when the gap N is at least (CL-1)+BL/2+W. N is the number of cycles since the auto-precharge command, so the next cycle is N=1. W is the recovery time in cycles. BL/2 is 4 when `cfg_bl8`=1 and 2 otherwise.
- R3: W equals the ceiling of `cfg_wtr_ps` divided by TCK_PS. With TCK_PS=5000, an input of 5000 gives 1 and an input of 5001 gives 2.
- R4: After a write with auto-precharge, a write (op 3) to another bank is allowed only when N ≥ BL/2.
- R5: After a read with auto-precharge (op 2, ap=1), a read to another bank is allowed only when N ≥ BL/2.
- R6: After a read with auto-precharge, a write to another bank is allowed only when N ≥ BL/2+2.
- R7: An activate (op 1) or single-bank precharge (op 4) to another bank is allowed from N=1 after either kind of auto-precharge command.
- R8: A precharge-all (op 5) is refused, with `cmd_viol`=1, while N is at most the longest gap for the tracked kind: (CL-1)+BL/2+W after a write, BL/2+2 after a read. From the next cycle on, it is allowed.
- R9: Commands to the tracked bank, other than precharge-all, are always allowed.
- R10: An accepted newer auto-precharge read or write replaces the tracked bank and kind, and N restarts from that command.
- R11: A refused command does not change the tracking. `cmd_viol` is high only when `cmd_valid` is high and `cmd_ok` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is presented this cycle |
| cmd_op | input | 3 | 0 nop, 1 activate, 2 read, 3 write, 4 precharge, 5 precharge-all, 6 refresh, 7 other |
| cmd_bank | input | BANK_W | Target bank |
| cmd_ap | input | 1 | Auto-precharge flag for a read or write |
| cfg_cl | input | 4 | CAS latency in cycles (at least 2) |
| cfg_bl8 | input | 1 | 1 for burst length 8, 0 for burst length 4 |
| cfg_wtr_ps | input | 16 | Write-to-read recovery time in picoseconds |
| cmd_ok | output | 1 | The presented command may issue this cycle |
| cmd_viol | output | 1 | The presented command breaks cross-bank spacing |

## Verification
The hardest state to reach is a replacement of the tracked command. A second auto-precharge command is only accepted when its own spacing rule allows it. So the stimulus issues a write with auto-precharge, waits exactly BL/2 cycles, and sends another write with auto-precharge to a third bank. Probes to the old bank then show that the counter restarted. A further sequence sends a read with auto-precharge while it is still too early. Later probes of a write gap then show that the refused command left the tracked kind unchanged.

// File: rtl/ap_gap_checker.sv
module ap_gap_checker #(
  parameter int BANK_W = 3,
  parameter int CNT_W  = 7,
  parameter int TCK_PS = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic              cmd_ap,
  input  logic [3:0]        cfg_cl,
  input  logic              cfg_bl8,
  input  logic [15:0]       cfg_wtr_ps,
  output logic              cmd_ok,
  output logic              cmd_viol
);
  localparam logic [2:0] OP_ACT = 3'd1, OP_RD = 3'd2, OP_WR = 3'd3,
                         OP_PRE = 3'd4, OP_PREA = 3'd5;

  logic              trk_valid, trk_wr;
  logic [BANK_W-1:0] trk_bank;
  logic [CNT_W-1:0]  trk_cnt;

  logic [CNT_W-1:0] half, wtr_cyc, gap_wr_rd, gap_rd_wr, span, need;
  logic             checked, same_bank, ap_load;

  assign half      = cfg_bl8 ? CNT_W'(4) : CNT_W'(2);
  assign wtr_cyc   = CNT_W'((32'(cfg_wtr_ps) + 32'(TCK_PS - 1)) / 32'(TCK_PS));
  assign gap_wr_rd = CNT_W'(cfg_cl) - CNT_W'(1) + half + wtr_cyc;
  assign gap_rd_wr = half + CNT_W'(2);
  assign span      = trk_wr ? gap_wr_rd : gap_rd_wr;

  always_comb begin
    case (cmd_op)
      OP_RD:   need = trk_wr ? gap_wr_rd : half;
      OP_WR:   need = trk_wr ? half : gap_rd_wr;
      default: need = CNT_W'(1);
    endcase
  end

  assign checked   = (cmd_op == OP_ACT) || (cmd_op == OP_RD) || (cmd_op == OP_WR) ||
                     (cmd_op == OP_PRE);
  assign same_bank = (cmd_bank == trk_bank);

  always_comb begin
    if (!trk_valid)              cmd_ok = 1'b1;
    else if (cmd_op == OP_PREA)  cmd_ok = 1'b0;
    else if (!checked)           cmd_ok = 1'b1;
    else if (same_bank)          cmd_ok = 1'b1;
    else                         cmd_ok = (trk_cnt >= need);
  end

  assign cmd_viol = cmd_valid && !cmd_ok;
  assign ap_load  = cmd_valid && cmd_ok && cmd_ap && ((cmd_op == OP_RD) || (cmd_op == OP_WR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trk_valid <= 1'b0;
      trk_wr    <= 1'b0;
      trk_bank  <= '0;
      trk_cnt   <= '0;
    end else if (ap_load) begin
      trk_valid <= 1'b1;
      trk_wr    <= (cmd_op == OP_WR);
      trk_bank  <= cmd_bank;
      trk_cnt   <= CNT_W'(1);
    end else if (trk_valid) begin
      if (trk_cnt >= span) trk_valid <= 1'b0;
      else                 trk_cnt   <= trk_cnt + CNT_W'(1);
    end
  end

  // R1
  idle_allows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !trk_valid |-> cmd_ok);

  // R8
  prea_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_PREA && trk_valid) |-> cmd_viol);

  // R7
  act_pre_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_valid && (cmd_op == OP_ACT || cmd_op == OP_PRE)) |-> cmd_ok);

  // R9
  same_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trk_valid && cmd_bank == trk_bank && cmd_op != OP_PREA) |-> cmd_ok);

  // R10
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ok && cmd_ap && (cmd_op == OP_RD || cmd_op == OP_WR))
      |=> (trk_valid && trk_cnt == CNT_W'(1) && trk_bank == $past(cmd_bank)));

  // R11
  refused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_viol && trk_valid && trk_cnt < span) |=> (trk_bank == $past(trk_bank) &&
      trk_wr == $past(trk_wr) && trk_cnt == $past(trk_cnt) + CNT_W'(1)));
endmodule

// File: tb/sim_ap_gap_checker.sv
module sim_ap_gap_checker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [2:0] cmd_bank = 3'd0;
  logic       cmd_ap = 1'b0;
  logic [3:0] cfg_cl = 4'd4;
  logic       cfg_bl8 = 1'b1;
  logic [15:0] cfg_wtr_ps = 16'd7500;
  logic       cmd_ok, cmd_viol;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ap_gap_checker u0 (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .cfg_cl(cfg_cl), .cfg_bl8(cfg_bl8),
    .cfg_wtr_ps(cfg_wtr_ps), .cmd_ok(cmd_ok), .cmd_viol(cmd_viol));

  // {req, op, bank, ap, exp_ok, exp_viol}; CL=4, BL=8, W=2
  localparam logic [12:0] VEC [18] = '{
    {4'd2, 3'd3, 3'd0, 1'b1, 1'b1, 1'b0}, // R2 write-ap bank0 starts tracking
    {4'd7, 3'd1, 3'd1, 1'b0, 1'b1, 1'b0}, // R7 activate N=1
    {4'd4, 3'd3, 3'd1, 1'b0, 1'b0, 1'b1}, // R4 write N=2
    {4'd4, 3'd3, 3'd1, 1'b0, 1'b0, 1'b1}, // R4 write N=3
    {4'd4, 3'd3, 3'd2, 1'b0, 1'b1, 1'b0}, // R4 write N=4
    {4'd2, 3'd2, 3'd1, 1'b0, 1'b0, 1'b1}, // R2 read N=5
    {4'd1, 3'd0, 3'd0, 1'b0, 1'b1, 1'b0}, // nop
    {4'd9, 3'd2, 3'd0, 1'b0, 1'b1, 1'b0}, // R9 same bank read N=7
    {4'd2, 3'd2, 3'd1, 1'b0, 1'b0, 1'b1}, // R2 read N=8
    {4'd2, 3'd2, 3'd1, 1'b0, 1'b1, 1'b0}, // R2 read N=9
    {4'd5, 3'd2, 3'd1, 1'b1, 1'b1, 1'b0}, // R5 read-ap bank1
    {4'd7, 3'd4, 3'd2, 1'b0, 1'b1, 1'b0}, // R7 precharge N=1
    {4'd5, 3'd2, 3'd2, 1'b0, 1'b0, 1'b1}, // R5 read N=2
    {4'd8, 3'd5, 3'd0, 1'b0, 1'b0, 1'b1}, // R8 precharge-all N=3
    {4'd5, 3'd2, 3'd2, 1'b0, 1'b1, 1'b0}, // R5 read N=4
    {4'd6, 3'd3, 3'd2, 1'b0, 1'b0, 1'b1}, // R6 write N=5
    {4'd6, 3'd3, 3'd3, 1'b0, 1'b1, 1'b0}, // R6 write N=6
    {4'd8, 3'd5, 3'd0, 1'b0, 1'b1, 1'b0}  // R8 precharge-all N=7 after window
  };

  task automatic drive(input logic [2:0] op, input logic [2:0] bank, input logic ap,
                       input logic valid = 1'b1);
    @(negedge clk);
    cmd_valid = valid; cmd_op = op; cmd_bank = bank; cmd_ap = ap;
    #1;
  endtask

  task automatic chk(input string tag, input logic exp_ok, input logic exp_viol);
    checks++;
    if (cmd_ok !== exp_ok || cmd_viol !== exp_viol) begin
      errors++;
      $display("FAIL %s: ok/viol got %b/%b expected %b/%b", tag, cmd_ok, cmd_viol,
               exp_ok, exp_viol);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(3'd0, 3'd0, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    drive(3'd5, 3'd0, 1'b0);
    chk("R1 precharge-all in reset", 1'b1, 1'b0);
    drive(3'd5, 3'd0, 1'b0);
    rst_n = 1'b1;
    drive(3'd2, 3'd1, 1'b0);
    chk("R1 read after reset", 1'b1, 1'b0);

    for (int v = 0; v < 18; v++) begin
      drive(VEC[v][8:6], VEC[v][5:3], VEC[v][2]);
      checks++;
      if (cmd_ok !== VEC[v][1] || cmd_viol !== VEC[v][0]) begin
        errors++;
        $display("FAIL R%0d vector %0d: ok/viol got %b/%b expected %b/%b", VEC[v][12:9], v,
                 cmd_ok, cmd_viol, VEC[v][1], VEC[v][0]);
      end
    end
    idle(20);

    // R3: CL=3, BL=4, 5000 ps -> W=1, read gap 5
    cfg_cl = 4'd3; cfg_bl8 = 1'b0; cfg_wtr_ps = 16'd5000;
    drive(3'd3, 3'd0, 1'b1); chk("R3 write-ap", 1'b1, 1'b0);
    idle(3);
    drive(3'd2, 3'd1, 1'b0); chk("R3 read N=4 W=1", 1'b0, 1'b1);
    drive(3'd2, 3'd1, 1'b0); chk("R3 read N=5 W=1", 1'b1, 1'b0);
    idle(20);
    cfg_wtr_ps = 16'd5001;
    drive(3'd3, 3'd0, 1'b1); chk("R3 write-ap", 1'b1, 1'b0);
    idle(4);
    drive(3'd2, 3'd1, 1'b0); chk("R3 read N=5 W=2", 1'b0, 1'b1);
    drive(3'd2, 3'd1, 1'b0); chk("R3 read N=6 W=2", 1'b1, 1'b0);
    idle(20);

    // R10: CL=4, BL=8, W=2; replacement by write-ap at N=4
    cfg_cl = 4'd4; cfg_bl8 = 1'b1; cfg_wtr_ps = 16'd7500;
    drive(3'd3, 3'd0, 1'b1); chk("R10 first write-ap", 1'b1, 1'b0);
    idle(3);
    drive(3'd3, 3'd2, 1'b1); chk("R10 second write-ap N=4", 1'b1, 1'b0);
    drive(3'd3, 3'd0, 1'b0); chk("R10 old bank write N=1 restarted", 1'b0, 1'b1);
    drive(3'd3, 3'd2, 1'b0); chk("R10 new bank same-bank write", 1'b1, 1'b0);
    drive(3'd3, 3'd0, 1'b0); chk("R10 old bank write N=3", 1'b0, 1'b1);
    drive(3'd3, 3'd0, 1'b0); chk("R10 old bank write N=4", 1'b1, 1'b0);
    idle(20);

    // R11: refused read-ap leaves write-ap tracking in place
    drive(3'd3, 3'd0, 1'b1); chk("R11 write-ap", 1'b1, 1'b0);
    drive(3'd2, 3'd1, 1'b1); chk("R11 early read-ap refused", 1'b0, 1'b1);
    drive(3'd5, 3'd0, 1'b0, 1'b0); chk("R11 invalid precharge-all no flag", 1'b0, 1'b0);
    drive(3'd3, 3'd2, 1'b0); chk("R11 write N=3 under write tracking", 1'b0, 1'b1);
    drive(3'd3, 3'd2, 1'b0); chk("R11 write N=4 under write tracking", 1'b1, 1'b0);
    idle(3);
    drive(3'd5, 3'd0, 1'b0); chk("R8 precharge-all N=8", 1'b0, 1'b1);
    drive(3'd5, 3'd0, 1'b0); chk("R8 precharge-all N=9 boundary", 1'b0, 1'b1);
    drive(3'd5, 3'd0, 1'b0); chk("R8 precharge-all N=10 expired", 1'b1, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule